// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block is a read-only direct-mapped cache placed between a processor read port and a slower main-memory port. Every cache line has a valid flag, a stored tag and a data block several bytes wide. An incoming read address is split into three fields. The low field picks a byte inside the block. The middle field picks one line. The high field is the tag that is compared against the line's stored tag.

When the selected line is valid and its tag matches, the read is a hit. The requested byte comes back one cycle later without a stall. Any other case is a miss. On a miss the controller raises a stall and issues one block-aligned fetch to memory. It then waits for the memory to answer and writes the whole block into the line, replacing whatever the line held. The same cycle's data also completes the pending read. Memory answers with a single valid pulse that carries the full block, after any number of cycles.

The controller is a two-state machine. ST_IDLE looks up each request. The transition "miss" goes from ST_IDLE to ST_FETCH. ST_FETCH holds the memory request. The transition "fill" goes from ST_FETCH back to ST_IDLE when the block arrives. A hit keeps the machine in ST_IDLE.

Top module: `dm_read_cache`

## Requirements
- R1: Field layout: the offset is address bits [OFF_W-1:0], the line index is the next IDX_W bits, and the tag is the remaining upper bits. With the default 4-bit address, 2-bit index and 1-bit offset, address 4'b1101 selects line 2 and byte 1.
- R2: A request accepted in ST_IDLE hits only when the indexed line is valid and its stored tag equals the address tag. A hit drives cpu_rvalid high in the following cycle with cpu_stall low and no memory request.
- R3: Reset clears every line's valid flag and leaves cpu_stall, cpu_rvalid and mem_rd_req low. Therefore the first access to any address after reset misses.
- R4: After a miss is accepted, cpu_stall is high from the next cycle until the fill. If memory raises mem_rd_valid L cycles after mem_rd_req first goes high, cpu_stall stays high for exactly L+1 cycles.
- R5: While mem_rd_req is high, mem_rd_addr holds the missing address's tag and index with all offset bits zero. It stays unchanged until mem_rd_valid is seen.
- R6: A fill writes the address tag, the fetched block and a set valid flag into the indexed line. Later reads of any byte of that block hit without a memory fetch.
- R7: Byte j of a block travels on mem_rd_block bits [BYTE_W*j+BYTE_W-1 : BYTE_W*j] and is stored as byte j of the line. cpu_rdata returns the byte selected by the address offset.
- R8: A miss always overwrites the indexed line. Alternating reads of two addresses with the same index and different tags therefore miss on every access.
- R9: Each accepted request produces exactly one single-cycle cpu_rvalid pulse. A request presented while cpu_stall is high is ignored: it causes no extra cpu_rvalid pulse and no extra memory fetch.
- R10: In the cycle after mem_rd_valid is seen in ST_FETCH, cpu_stall is low and cpu_rvalid is high, with the requested byte taken from the fetched block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, taken only while cpu_stall is low |
| cpu_addr | input | ADDR_W | Read byte address |
| cpu_stall | output | 1 | High while a miss is being filled |
| cpu_rvalid | output | 1 | One-cycle pulse: cpu_rdata is valid |
| cpu_rdata | output | BYTE_W | Returned byte |
| mem_rd_req | output | 1 | Block fetch request, held until mem_rd_valid |
| mem_rd_addr | output | ADDR_W | Block-aligned fetch address |
| mem_rd_valid | input | 1 | Pulse: mem_rd_block carries the requested block |
| mem_rd_block | input | BYTE_W*2**OFF_W | Fetched block, byte j at slice j |

## Verification
The hardest situation to produce from the ports is a request that arrives while a fill is in flight. A related hard case is an index whose line is replaced over and over by different tags. The bench reaches the first case by raising cpu_req, with an address of a different tag, in the first stall cycle of a miss. It then checks that only one rvalid pulse and one fetch follow. It reaches the second case with full address sweeps that reload every line under new tags, and with an alternating pair of addresses that share an index. A second reset in mid-run confirms that lines which were full before the reset miss again. Memory latency is varied between sweeps so the stall length is checked against several values of L.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 1,
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_block,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_block
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_block;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_block = data_q[rd_idx];
endmodule

// File: rtl/dmc_tag_cmp.sv
module dmc_tag_cmp #(
    parameter int TAG_W = 1
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] addr_tag,
    output logic             hit
);
    always_comb begin
        hit = line_valid && (line_tag == addr_tag);
    end
endmodule

// File: rtl/dmc_byte_sel.sv
module dmc_byte_sel #(
    parameter int OFF_W  = 1,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W*(1<<OFF_W)-1:0] block,
    input  logic [OFF_W-1:0]             offset,
    output logic [BYTE_W-1:0]            byte_out
);
    localparam int NBYTES = 1 << OFF_W;

    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        assign lanes[j] = block[j*BYTE_W +: BYTE_W];
    end

    assign byte_out = lanes[offset];
endmodule

// File: rtl/dmc_ctl.sv
module dmc_ctl
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic lookup_hit,
    input  logic mem_rd_valid,
    output logic stall,
    output logic mem_req,
    output logic hit_ack,
    output logic miss_take,
    output logic fill_en
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && !lookup_hit) state_d = ST_FETCH;
            ST_FETCH: if (mem_rd_valid)           state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        stall     = 1'b0;
        mem_req   = 1'b0;
        hit_ack   = 1'b0;
        miss_take = 1'b0;
        fill_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                hit_ack   = cpu_req && lookup_hit;
                miss_take = cpu_req && !lookup_hit;
            end
            ST_FETCH: begin
                stall   = 1'b1;
                mem_req = 1'b1;
                fill_en = mem_rd_valid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic [ADDR_W-1:0]             cpu_addr,
    output logic                          cpu_stall,
    output logic                          cpu_rvalid,
    output logic [BYTE_W-1:0]             cpu_rdata,
    output logic                          mem_rd_req,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    input  logic                          mem_rd_valid,
    input  logic [BYTE_W*(1<<OFF_W)-1:0]  mem_rd_block
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = BYTE_W * (1 << OFF_W);

    logic [TAG_W-1:0]  cpu_tag, pend_tag, line_tag;
    logic [IDX_W-1:0]  cpu_idx, pend_idx;
    logic [OFF_W-1:0]  cpu_off, pend_off;
    logic              line_valid, lookup_hit;
    logic [BLK_W-1:0]  line_block;
    logic [BYTE_W-1:0] hit_byte, fill_byte;
    logic              hit_ack, miss_take, fill_en;

    assign cpu_off = cpu_addr[OFF_W-1:0];
    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cpu_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_block (line_block),
        .wr_en    (fill_en),
        .wr_idx   (pend_idx),
        .wr_tag   (pend_tag),
        .wr_block (mem_rd_block)
    );

    dmc_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .addr_tag   (cpu_tag),
        .hit        (lookup_hit)
    );

    dmc_byte_sel #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_hit_sel (
        .block    (line_block),
        .offset   (cpu_off),
        .byte_out (hit_byte)
    );

    dmc_byte_sel #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_fill_sel (
        .block    (mem_rd_block),
        .offset   (pend_off),
        .byte_out (fill_byte)
    );

    dmc_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .lookup_hit   (lookup_hit),
        .mem_rd_valid (mem_rd_valid),
        .stall        (cpu_stall),
        .mem_req      (mem_rd_req),
        .hit_ack      (hit_ack),
        .miss_take    (miss_take),
        .fill_en      (fill_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag <= '0;
            pend_idx <= '0;
            pend_off <= '0;
        end else if (miss_take) begin
            pend_tag <= cpu_tag;
            pend_idx <= cpu_idx;
            pend_off <= cpu_off;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= hit_ack || fill_en;
            if (fill_en) begin
                cpu_rdata <= fill_byte;
            end else if (hit_ack) begin
                cpu_rdata <= hit_byte;
            end
        end
    end

    assign mem_rd_addr = {pend_tag, pend_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
    parameter int ADDR_W = 4,
    parameter int OFF_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_stall,
    input logic              cpu_rvalid,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              lookup_hit
);
    // R2
    hit_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_stall && lookup_hit) |=> (cpu_rvalid && !cpu_stall && !mem_rd_req));

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_stall && !lookup_hit) |=> (cpu_stall && mem_rd_req && !cpu_rvalid));

    // R5
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

    // R5
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R10
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && mem_rd_valid) |=> (!cpu_stall && cpu_rvalid));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && !mem_rd_valid) |=> !cpu_rvalid);
endmodule

bind dm_read_cache dmc_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_stall    (cpu_stall),
    .cpu_rvalid   (cpu_rvalid),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .lookup_hit   (lookup_hit)
);

// File: tb/sim_dm_read_cache.sv
module sim_dm_read_cache;
    localparam int CLK_PERIOD = 10;
    localparam int A_W = 4;
    localparam int I_W = 2;
    localparam int O_W = 1;
    localparam int B_W = 8;
    localparam int NB  = 1 << O_W;
    localparam int NL  = 1 << I_W;
    localparam int NA  = 1 << A_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_req = 1'b0;
    logic [A_W-1:0]  cpu_addr = '0;
    logic            cpu_stall, cpu_rvalid;
    logic [B_W-1:0]  cpu_rdata;
    logic            mem_rd_req;
    logic [A_W-1:0]  mem_rd_addr;
    logic            mem_rd_valid = 1'b0;
    logic [B_W*NB-1:0] mem_rd_block = '0;

    int vectors = 0;
    int errors  = 0;
    int fetches = 0;
    int mem_lat = 1;
    int lat_cnt = 0;

    bit mval [NL];
    int mtag [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_read_cache #(.ADDR_W(A_W), .IDX_W(I_W), .OFF_W(O_W), .BYTE_W(B_W)) u0 (
        .clk, .rst_n, .cpu_req, .cpu_addr, .cpu_stall, .cpu_rvalid, .cpu_rdata,
        .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_block
    );

    function automatic logic [B_W-1:0] mem_byte(int a);
        return B_W'(a * 29 + 11);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            lat_cnt      <= 0;
        end else if (mem_rd_req && !mem_rd_valid) begin
            if (lat_cnt + 1 >= mem_lat) begin
                mem_rd_valid <= 1'b1;
                lat_cnt      <= 0;
                fetches      <= fetches + 1;
                for (int j = 0; j < NB; j++)
                    mem_rd_block[j*B_W +: B_W] <= mem_byte(int'(mem_rd_addr) + j);
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_rd_valid <= 1'b0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        cpu_req = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NL; i++) mval[i] = 1'b0;
        chk(cpu_stall == 1'b0, "R3", "stall in reset", cpu_stall, 0);
        chk(cpu_rvalid == 1'b0, "R3", "rvalid in reset", cpu_rvalid, 0);
        chk(mem_rd_req == 1'b0, "R3", "mem req in reset", mem_rd_req, 0);
        rst_n = 1'b1;
    endtask

    // Returns 1 when the access was expected to hit.
    task automatic rd(int a, bit poke, string tagname, output bit was_hit);
        int idx = (a >> O_W) % NL;
        int tg  = a >> (O_W + I_W);
        bit exp_hit = mval[idx] && (mtag[idx] == tg);
        int f0 = fetches;
        int stalls = 0;
        was_hit = exp_hit;
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = A_W'(a);
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_hit) begin
            chk(cpu_rvalid && !cpu_stall, "R2", "hit reply", {cpu_rvalid, cpu_stall}, 2);
            chk(mem_rd_req == 1'b0, "R6", "no fetch on hit", mem_rd_req, 0);
            chk(cpu_rdata == mem_byte(a), "R7", "hit byte", cpu_rdata, mem_byte(a));
        end else begin
            chk(cpu_stall == 1'b1, "R4", "stall after miss", cpu_stall, 1);
            chk(mem_rd_addr == A_W'((a >> O_W) << O_W), "R5", "aligned fetch addr",
                mem_rd_addr, (a >> O_W) << O_W);
            while (!cpu_rvalid && stalls < 200) begin
                if (!cpu_stall) chk(0, "R4", "stall dropped early", stalls, mem_lat + 1);
                if (poke && stalls == 0) begin
                    cpu_req  = 1'b1;
                    cpu_addr = A_W'(a ^ (1 << (A_W - 1)));
                end
                stalls++;
                @(negedge clk);
                cpu_req = 1'b0;
            end
            chk(stalls == mem_lat + 1, "R4", "stall length", stalls, mem_lat + 1);
            chk(!cpu_stall, "R10", "stall low at reply", cpu_stall, 0);
            chk(cpu_rdata == mem_byte(a), "R10", "fill byte", cpu_rdata, mem_byte(a));
            mval[idx] = 1'b1;
            mtag[idx] = tg;
        end
        @(negedge clk);
        chk(!cpu_rvalid && !cpu_stall && !mem_rd_req, "R9", "single pulse, idle after",
            {cpu_rvalid, cpu_stall, mem_rd_req}, 0);
        chk(fetches - f0 == (exp_hit ? 0 : 1), tagname, "fetch count", fetches - f0,
            exp_hit ? 0 : 1);
    endtask

    initial begin
        bit h;
        do_reset();

        // R3: every address misses after reset; R6: its block partner then hits
        mem_lat = 1;
        for (int a = 0; a < NA; a++) rd(a, 1'b0, "R6", h);
        for (int a = 0; a < NA; a++) begin
            rd(a, 1'b0, "R6", h);
            if ((a % NB) != 0) chk(h, "R6", "block partner hit", h, 1);
        end

        // R1: 1100 fills line 2; 1101 returns byte 1 of that line as a hit
        mem_lat = 2;
        rd(12, 1'b0, "R1", h);
        rd(13, 1'b0, "R1", h);
        chk(h, "R1", "addr 1101 hits line 2 byte 1", h, 1);

        // R8: same index, different tag, alternating: all miss
        mem_lat = 3;
        for (int k = 0; k < 6; k++) begin
            rd((k % 2 == 0) ? 2 : 10, 1'b0, "R8", h);
            chk(!h, "R8", "alternating conflict miss", h, 0);
        end

        // R9: request raised during a fill is ignored
        mem_lat = 4;
        for (int a = 0; a < NA; a += 3) rd(a, 1'b1, "R9", h);

        // Descending sweep with another latency
        mem_lat = 2;
        for (int a = NA - 1; a >= 0; a--) rd(a, 1'b0, "R7", h);

        // R3: second reset empties every line
        do_reset();
        mem_lat = 1;
        for (int a = 0; a < NA; a += NB) begin
            rd(a, 1'b0, "R3", h);
            chk(!h, "R3", "miss after reset", h, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule